// File: doc/BRIEF.md
# Dual Reloading Down Counter Timer

Two 16-bit down counters, called L and H, run from a shared count-clock tick. Each counter has two registers. One holds the start value and the other holds the live count. On every count step a running counter decrements by one. When a step brings it to zero, the counter raises a one-cycle zero strobe. On the next step it reloads its start value and keeps counting. So a counter started from S repeats every S+1 steps.

Each counter can put a divide-by-four prescaler in front of its count tick. Each output can be a pulse or a square wave. The two counters can also be joined into one 32-bit counter. In that mode L is the low half and the H settings govern both halves.

Register access uses a plain single-cycle write strobe with a select and a combinational read mux. There is no back-pressure: every write is taken on the edge where `wr_en` is high. The write is either applied or, for a live-count write while the counter runs, dropped. The live count is read through a readable copy. The copy follows the count while unfrozen and holds still while frozen.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every start value, live count and readable copy is zero, both counters are halted, and `zero_l`, `zero_h`, `out_l` and `out_h` are low.
- R2: A count step happens on a clock edge where the counter runs and `tick` is high; when prescaling is on, only on every fourth such edge. On a step, a running counter whose live count is non-zero decrements by exactly one.
- R3: On a step where the live count is zero, the counter loads the start value held at that edge instead of decrementing.
- R4: The zero strobe of a counter is high for exactly the cycle after a step whose result is zero. This covers a decrement from 1, and also a reload when the start value is 0.
- R5: With the prescaler on, and counting after a halt, the first three ticks leave the count unchanged and the fourth tick decrements it.
- R6: A write to a live-count register is applied only while its counter is halted; while it runs the write is dropped and the count is unchanged.
- R7: Start-value registers can be written and read back at any time, running or not. Write/read select encoding: 0 = L start, 1 = H start, 2 = L live count, 3 = H live count.
- R8: While a counter's freeze input is high, its readable copy holds its value. While low, the copy equals the live count after the same edge.
- R9: In pulse mode (`sqw`=0) an output equals the zero strobe. In square mode (`sqw`=1) the output inverts on each zero event and holds otherwise.
- R10: With `chain` high, the count is the 32-bit value {H,L}. L decrements on every step and wraps from 0 to 0xFFFF, and H decrements on the steps where L wraps. `run_h`, `div_h`, `frz_h` and `sqw_h` govern both halves. `zero_l` stays low and `out_l` does not change.
- R11: In chained mode, a step from {0,1} raises `zero_h`. The step after that, from {0,0}, reloads both halves from their start values together.
- R12: A halted counter keeps its live count regardless of `tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-clock enable, one pulse per count-clock period |
| chain | input | 1 | Join L and H into one 32-bit counter |
| run_l | input | 1 | L counts when high, halted when low |
| run_h | input | 1 | H counts when high (both halves when chained) |
| div_l | input | 1 | Divide-by-four prescaler for L |
| div_h | input | 1 | Divide-by-four prescaler for H |
| frz_l | input | 1 | Freeze L readable copy |
| frz_h | input | 1 | Freeze H readable copy |
| sqw_l | input | 1 | L output form: 1 square, 0 pulse |
| sqw_h | input | 1 | H output form: 1 square, 0 pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target (encoding in R7) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read source (encoding in R7) |
| rd_data | output | 16 | Read data, combinational |
| zero_l | output | 1 | L zero strobe |
| zero_h | output | 1 | H (or 32-bit) zero strobe |
| out_l | output | 1 | L timer output |
| out_h | output | 1 | H timer output |

## Verification
The assertions assume that the configuration inputs (`chain`, the run, prescale and output-form bits) change only while the affected counter is halted or between steps. They also assume `wr_sel` is stable whenever `wr_en` is high. The stimulus drives every input on the falling clock edge and changes `chain` and the prescale bits only after halting both counters. Ticks are applied one edge at a time, so each count step lands on a known edge and can be checked there.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [1:0] {
    SEL_L_START = 2'd0,
    SEL_H_START = 2'd1,
    SEL_L_CUR   = 2'd2,
    SEL_H_CUR   = 2'd3
  } reg_sel_e;

  localparam int NUM_CNT = 2;
  localparam int IDX_L   = 0;
  localparam int IDX_H   = 1;
endpackage

// File: rtl/dt_prescale.sv
module dt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_on,
  input  logic tick,
  output logic step
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign step = run && tick && (!div_on || (pcnt == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt <= '0;
    end else if (tick && div_on) begin
      pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end
  end

  // R5: with division on, two steps never fall on back-to-back edges
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div_on && run && $past(run) && $past(div_on)) |=> !step);
endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halted,
  input  logic         wr_start,
  input  logic         wr_cur,
  input  logic [W-1:0] wdata,
  input  logic         dec,
  input  logic         load,
  input  logic         frz,
  output logic [W-1:0] cur,
  output logic [W-1:0] start,
  output logic [W-1:0] snap
);
  logic [W-1:0] cur_next;

  always_comb begin
    if (load)                 cur_next = start;
    else if (dec)             cur_next = cur - 1'b1;
    else if (wr_cur && halted) cur_next = wdata;
    else                      cur_next = cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      start <= '0;
      snap  <= '0;
    end else begin
      cur <= cur_next;
      if (wr_start) start <= wdata;
      if (!frz) snap <= cur_next;
    end
  end

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cur == $past(cur) - 1'b1));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(start)));

  p_wrbusy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur && !halted && !dec && !load) |=> $stable(cur));

  p_frz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frz |=> $stable(snap));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_cur) |=> $stable(cur));
endmodule

// File: rtl/dt_wave.sv
module dt_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic sqw,
  output logic zero,
  output logic out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero <= 1'b0;
      out  <= 1'b0;
    end else begin
      zero <= evt;
      out  <= sqw ? (out ^ evt) : evt;
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw |=> (out == zero));

  p_square_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sqw && !evt) |=> $stable(out));
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         chain,
  input  logic         run_l,
  input  logic         run_h,
  input  logic         div_l,
  input  logic         div_h,
  input  logic         frz_l,
  input  logic         frz_h,
  input  logic         sqw_l,
  input  logic         sqw_h,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         zero_l,
  output logic         zero_h,
  output logic         out_l,
  output logic         out_h
);
  import dt_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  logic [NUM_CNT-1:0] run_e, div_e, frz_e, sqw_e, step_r;
  logic [NUM_CNT-1:0] wr_start, wr_cur, dec, load, evt;
  logic [NUM_CNT-1:0] cur_z, start_z, zero_v, out_v;
  logic [W-1:0]       cur   [NUM_CNT];
  logic [W-1:0]       start [NUM_CNT];
  logic [W-1:0]       snap  [NUM_CNT];
  logic               all_zero;
  reg_sel_e           wsel, rsel;

  // Effective controls: in chained mode the H bits govern the L half too.
  always_comb begin
    run_e[IDX_H] = run_h;
    div_e[IDX_H] = div_h;
    frz_e[IDX_H] = frz_h;
    sqw_e[IDX_H] = sqw_h;
    run_e[IDX_L] = chain ? run_h : run_l;
    div_e[IDX_L] = chain ? div_h : div_l;
    frz_e[IDX_L] = chain ? frz_h : frz_l;
    sqw_e[IDX_L] = sqw_l;
  end

  assign wsel = reg_sel_e'(wr_sel);
  assign rsel = reg_sel_e'(rd_sel);

  always_comb begin
    wr_start[IDX_L] = wr_en && (wsel == SEL_L_START);
    wr_start[IDX_H] = wr_en && (wsel == SEL_H_START);
    wr_cur[IDX_L]   = wr_en && (wsel == SEL_L_CUR);
    wr_cur[IDX_H]   = wr_en && (wsel == SEL_H_CUR);
  end

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      cur_z[i]   = (cur[i] == '0);
      start_z[i] = (start[i] == '0);
    end
    all_zero = cur_z[IDX_L] && cur_z[IDX_H];
  end

  // Step decode: independent counters or one counter of twice the width.
  always_comb begin
    if (chain) begin
      load[IDX_L] = step_r[IDX_H] && all_zero;
      load[IDX_H] = step_r[IDX_H] && all_zero;
      dec[IDX_L]  = step_r[IDX_H] && !all_zero;
      dec[IDX_H]  = step_r[IDX_H] && !all_zero && cur_z[IDX_L];
      evt[IDX_L]  = 1'b0;
      evt[IDX_H]  = step_r[IDX_H] &&
                    ((cur_z[IDX_H] && (cur[IDX_L] == ONE)) ||
                     (all_zero && start_z[IDX_L] && start_z[IDX_H]));
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        load[i] = step_r[i] && cur_z[i];
        dec[i]  = step_r[i] && !cur_z[i];
        evt[i]  = step_r[i] && ((cur[i] == ONE) || (cur_z[i] && start_z[i]));
      end
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dt_prescale #(.DIV(DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_e[g]),
      .div_on (div_e[g]),
      .tick   (tick),
      .step   (step_r[g])
    );

    dt_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .halted   (!run_e[g]),
      .wr_start (wr_start[g]),
      .wr_cur   (wr_cur[g]),
      .wdata    (wr_data),
      .dec      (dec[g]),
      .load     (load[g]),
      .frz      (frz_e[g]),
      .cur      (cur[g]),
      .start    (start[g]),
      .snap     (snap[g])
    );

    dt_wave u_wave (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt[g]),
      .sqw   (sqw_e[g]),
      .zero  (zero_v[g]),
      .out   (out_v[g])
    );
  end

  always_comb begin
    unique case (rsel)
      SEL_L_START: rd_data = start[IDX_L];
      SEL_H_START: rd_data = start[IDX_H];
      SEL_L_CUR:   rd_data = snap[IDX_L];
      default:     rd_data = snap[IDX_H];
    endcase
  end

  assign zero_l = zero_v[IDX_L];
  assign zero_h = zero_v[IDX_H];
  assign out_l  = out_v[IDX_L];
  assign out_h  = out_v[IDX_H];

  // R10: a chained L half never strobes
  p_lquiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> !zero_l);

  // R11: the 32-bit reload moves both halves on the same edge
  p_joint_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && step_r[IDX_H] && all_zero) |=>
      (cur[IDX_L] == $past(start[IDX_L]) && cur[IDX_H] == $past(start[IDX_H])));

  // R1: outputs low on the first cycle out of reset
  p_rst_r1: assert property (@(posedge clk)
    !rst_n |=> (!zero_l && !zero_h && !out_l && !out_h));
endmodule

// File: tb/sim_dual_down_timer.sv
module sim_dual_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, chain = 0, run_l = 0, run_h = 0;
  logic        div_l = 0, div_h = 0, frz_l = 0, frz_h = 0, sqw_l = 0, sqw_h = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        zero_l, zero_h, out_l, out_h;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_down_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chain(chain),
    .run_l(run_l), .run_h(run_h), .div_l(div_l), .div_h(div_h),
    .frz_l(frz_l), .frz_h(frz_h), .sqw_l(sqw_l), .sqw_h(sqw_h),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .zero_l(zero_l), .zero_h(zero_h), .out_l(out_l), .out_h(out_h)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] sel, logic [15:0] exp, string tag);
    rd_sel = sel;
    #1;
    chk(tag, {16'h0, rd_data}, {16'h0, exp});
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic t_reset;
    rd(2'd0, 16'h0, "R1 L start");
    rd(2'd1, 16'h0, "R1 H start");
    rd(2'd2, 16'h0, "R1 L count");
    rd(2'd3, 16'h0, "R1 H count");
    chk("R1 outputs", {zero_l, zero_h, out_l, out_h}, 4'b0);
  endtask

  task automatic t_basic_l;
    wr(2'd0, 16'd3);
    wr(2'd2, 16'd3);
    rd(2'd2, 16'd3, "R6 halted write");
    run_l = 1;
    step(1); rd(2'd2, 16'd2, "R2 dec 3->2");
    chk("R4 no strobe", zero_l, 0);
    step(1); rd(2'd2, 16'd1, "R2 dec 2->1");
    step(1); rd(2'd2, 16'd0, "R2 dec 1->0");
    chk("R4 strobe at zero", zero_l, 1);
    chk("R9 pulse out", out_l, 1);
    step(1); rd(2'd2, 16'd3, "R3 reload");
    chk("R4 strobe one cycle", zero_l, 0);
    chk("R9 pulse ends", out_l, 0);
  endtask

  task automatic t_freeze;
    frz_l = 1;
    step(2);
    rd(2'd2, 16'd3, "R8 frozen copy holds");
    frz_l = 0;
    @(negedge clk);
    rd(2'd2, 16'd1, "R8 copy tracks after unfreeze");
  endtask

  task automatic t_busy_write;
    wr(2'd2, 16'h0055);
    rd(2'd2, 16'd1, "R6 write while running dropped");
    wr(2'd0, 16'd7);
    rd(2'd0, 16'd7, "R7 start write while running");
    step(1); rd(2'd2, 16'd0, "R2 dec to zero");
    step(1); rd(2'd2, 16'd7, "R3 reload new start");
  endtask

  task automatic t_halt;
    run_l = 0;
    step(2);
    rd(2'd2, 16'd7, "R12 halted holds");
    chk("R12 no strobe", zero_l, 0);
  endtask

  task automatic t_presc;
    wr(2'd2, 16'd10);
    div_l = 1; run_l = 1;
    step(3);
    rd(2'd2, 16'd10, "R5 three ticks no step");
    step(1);
    rd(2'd2, 16'd9, "R5 fourth tick steps");
    step(4);
    rd(2'd2, 16'd8, "R5 next four ticks");
    run_l = 0; div_l = 0;
  endtask

  task automatic t_square_h;
    wr(2'd1, 16'd1);
    wr(2'd3, 16'd1);
    sqw_h = 1; run_h = 1;
    step(1);
    chk("R9 square rises", out_h, 1);
    chk("R4 H strobe", zero_h, 1);
    step(1);
    chk("R9 square holds", out_h, 1);
    rd(2'd3, 16'd1, "R3 H reload");
    step(1);
    chk("R9 square falls", out_h, 0);
    run_h = 0; sqw_h = 0;
  endtask

  task automatic t_start_zero;
    wr(2'd1, 16'd0);
    wr(2'd3, 16'd0);
    run_h = 1;
    step(1);
    chk("R4 start zero strobe", zero_h, 1);
    step(1);
    chk("R4 start zero strobe again", zero_h, 1);
    rd(2'd3, 16'd0, "R3 reload zero");
    run_h = 0;
    @(negedge clk);
  endtask

  task automatic t_chain;
    chain = 1;
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd0);
    wr(2'd3, 16'd1);
    run_h = 1;
    step(1);
    rd(2'd2, 16'hFFFF, "R10 L wraps");
    rd(2'd3, 16'd0, "R10 H borrows");
    chk("R10 no strobe", {zero_l, zero_h}, 2'b00);
    wr(2'd2, 16'h1234);
    rd(2'd2, 16'hFFFF, "R10 L write dropped while H runs");
    run_h = 0;
    wr(2'd2, 16'd1);
    wr(2'd3, 16'd0);
    run_h = 1;
    step(1);
    chk("R11 32-bit zero strobe", zero_h, 1);
    chk("R10 L strobe quiet", zero_l, 0);
    chk("R10 L out quiet", out_l, 0);
    step(1);
    rd(2'd2, 16'd0, "R11 L reloaded");
    rd(2'd3, 16'd1, "R11 H reloaded");
    run_h = 0; chain = 0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic_l();
    t_freeze();
    t_busy_write();
    t_halt();
    t_presc();
    t_square_h();
    t_start_zero();
    t_chain();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule